// File: doc/BRIEF.md
# Masked Trigger Combiner with Busy Latch

This block forms a board-level trigger from four channel discriminator outputs and one external trigger input. A 16-bit configuration word holds two five-bit enable masks. Sources enabled in the "any" mask fire the trigger as soon as one of them is high. Sources enabled in the "all" mask fire it only when every one of them is high at once. The five inputs are first brought into the clock domain. The trigger is then taken on the rising edge of the combined condition, so a level that stays high yields one event.

Each accepted trigger produces a one-cycle internal trigger pulse and sets the trigger-out line. In busy mode the line stays high until the host pulses a restart strobe, which it does once readout is finished and acquisition has been restarted. External logic can therefore re-arm on the falling edge of the line. In pulse mode the line gives a fixed-width pulse of a parameterised number of clock cycles and the strobe is not used. In both modes no new trigger is accepted while the line is high.

Top module: `trig_combiner`

## Requirements
- R1: While rst_n is low and in the first cycle after it, trig_int and trig_out are 0.
- R2: The "any" mask occupies cfg_word bits 0 to 4, where bit 0 enables src_ch[0], bit 1 src_ch[1], bit 2 src_ch[2], bit 3 src_ch[3] and bit 4 src_ext. Any enabled source that is high makes the combined condition true.
- R3: The "all" mask occupies cfg_word bits 8 to 12, with the same source order starting at bit 8. It makes the condition true only when every enabled source is high. When all five of these bits are zero, this group never fires.
- R4: A source change that is first sampled at rising edge k shows on trig_int and trig_out right after rising edge k+2.
- R5: trig_int is a one-cycle pulse, given only on a rising edge of the combined condition. A condition held high yields one trigger, even across a restart.
- R6: With mode_pulse=0 (busy mode), trig_out stays high after a trigger. It goes low right after the first rising edge at which rearm is sampled high.
- R7: In both modes, while trig_out is high a rising edge of the condition is ignored. After release, a new rising edge is needed.
- R8: With mode_pulse=1 (pulse mode), trig_out is high for exactly PULSE_CYC cycles per trigger, and rearm has no effect.
- R9: A rearm strobe while trig_out is low has no effect on either output.
- R10: cfg_word bits 5 to 7 and 13 to 15 have no effect, and a source whose enable bits are both clear cannot cause a trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_ch | input | 4 | Channel discriminator outputs, asynchronous |
| src_ext | input | 1 | External trigger input, asynchronous |
| cfg_word | input | 16 | Any-mask in bits 4:0, all-mask in bits 12:8 |
| mode_pulse | input | 1 | 0 = busy latch, 1 = fixed-width pulse |
| rearm | input | 1 | Readout-done and restart strobe |
| trig_int | output | 1 | One-cycle internal trigger |
| trig_out | output | 1 | Trigger-out / busy line |

## Verification
The assertions assume that cfg_word and mode_pulse do not change while trig_out is high. In particular, the hold and pulse-length properties read mode_pulse as the mode of the trigger in flight. The bench changes the configuration and the mode only after a restart has released the line and the sources are low. The sources themselves may toggle at any cycle, including while the line is busy, because the ignore rule is part of what is checked. Each source value is held for at least one clock so that the synchronizer samples it.

// File: rtl/trig_comb_pkg.sv
package trig_comb_pkg;
  typedef enum logic {
    OUT_BUSY  = 1'b0,
    OUT_PULSE = 1'b1
  } out_mode_e;
endpackage

// File: rtl/trig_sync.sv
module trig_sync #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) pipe[0] <= '0;
    else        pipe[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) pipe[s] <= '0;
      else        pipe[s] <= pipe[s-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/trig_cond.sv
module trig_cond #(
  parameter int N_SRC   = 5,
  parameter int CFG_W   = 16,
  parameter int ANY_LSB = 0,
  parameter int ALL_LSB = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src,
  input  logic [CFG_W-1:0] cfg,
  input  logic             busy,
  output logic             cond,
  output logic             cond_rise,
  output logic             accept
);
  function automatic logic any_hit(input logic [N_SRC-1:0] s,
                                   input logic [N_SRC-1:0] m);
    return |(s & m);
  endfunction

  function automatic logic all_hit(input logic [N_SRC-1:0] s,
                                   input logic [N_SRC-1:0] m);
    return (|m) && ((s & m) == m);
  endfunction

  logic [N_SRC-1:0] any_mask, all_mask;
  logic             cond_q;

  assign any_mask  = cfg[ANY_LSB +: N_SRC];
  assign all_mask  = cfg[ALL_LSB +: N_SRC];
  assign cond      = any_hit(src, any_mask) || all_hit(src, all_mask);
  assign cond_rise = cond && !cond_q;
  assign accept    = cond_rise && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) cond_q <= 1'b0;
    else        cond_q <= cond;
  end

  AST_RISE_NOT_TWICE: assert property (@(posedge clk) disable iff (!rst_n)
    cond_rise |=> !cond_rise); // R5
endmodule

// File: rtl/trig_out_ctrl.sv
module trig_out_ctrl
  import trig_comb_pkg::*;
#(
  parameter int PULSE_CYC = 15
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      accept,
  input  out_mode_e mode,
  input  logic      rearm,
  output logic      trig_int,
  output logic      trig_out
);
  localparam int CNT_W = $clog2(PULSE_CYC + 2);

  logic [CNT_W-1:0] left_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trig_int <= 1'b0;
      trig_out <= 1'b0;
      left_q   <= '0;
    end else begin
      trig_int <= accept;
      if (accept) begin
        trig_out <= 1'b1;
        left_q   <= CNT_W'(PULSE_CYC - 1);
      end else if (trig_out) begin
        if (mode == OUT_PULSE) begin
          if (left_q == '0) trig_out <= 1'b0;
          else              left_q   <= left_q - 1'b1;
        end else if (rearm) begin
          trig_out <= 1'b0;
        end
      end
    end
  end

  logic [CNT_W-1:0] hi_run;
  always_ff @(posedge clk) begin
    if (!rst_n)        hi_run <= '0;
    else if (trig_out) hi_run <= hi_run + 1'b1;
    else               hi_run <= '0;
  end

  AST_INT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    trig_int |=> !trig_int); // R5
  AST_INT_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    trig_int |-> !$past(trig_out)); // R7
  AST_RISE_HAS_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trig_out) |-> trig_int); // R4
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_out && !rearm && mode == OUT_BUSY) |=> trig_out); // R6
  AST_BUSY_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_out && rearm && mode == OUT_BUSY) |=> !trig_out); // R6
  AST_PULSE_NOT_LONG: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_out && mode == OUT_PULSE) |-> (hi_run < CNT_W'(PULSE_CYC))); // R8
  AST_PULSE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(trig_out) && mode == OUT_PULSE) |-> (hi_run == CNT_W'(PULSE_CYC))); // R8
endmodule

// File: rtl/trig_combiner.sv
module trig_combiner
  import trig_comb_pkg::*;
#(
  parameter int N_CH        = 4,
  parameter int CFG_W       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int PULSE_CYC   = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_CH-1:0]  src_ch,
  input  logic             src_ext,
  input  logic [CFG_W-1:0] cfg_word,
  input  logic             mode_pulse,
  input  logic             rearm,
  output logic             trig_int,
  output logic             trig_out
);
  localparam int N_SRC   = N_CH + 1;
  localparam int ANY_LSB = 0;
  localparam int ALL_LSB = CFG_W / 2;

  logic [N_SRC-1:0] src_raw, src_s;
  logic             cond, cond_rise, accept;
  out_mode_e        mode;

  assign src_raw = {src_ext, src_ch};
  assign mode    = out_mode_e'(mode_pulse);

  trig_sync #(.W(N_SRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(src_raw), .q(src_s)
  );

  trig_cond #(.N_SRC(N_SRC), .CFG_W(CFG_W), .ANY_LSB(ANY_LSB), .ALL_LSB(ALL_LSB)) u_cond (
    .clk(clk), .rst_n(rst_n), .src(src_s), .cfg(cfg_word), .busy(trig_out),
    .cond(cond), .cond_rise(cond_rise), .accept(accept)
  );

  trig_out_ctrl #(.PULSE_CYC(PULSE_CYC)) u_out (
    .clk(clk), .rst_n(rst_n), .accept(accept), .mode(mode), .rearm(rearm),
    .trig_int(trig_int), .trig_out(trig_out)
  );

  AST_TRIG_FROM_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    trig_int |-> $past(cond_rise)); // R5
  AST_IDLE_REARM: assert property (@(posedge clk) disable iff (!rst_n)
    (!trig_out && !accept) |=> !trig_out); // R9
endmodule

// File: tb/trig_combiner_test.sv
`timescale 1ns/1ps
module trig_combiner_test;
  localparam int P = 15;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  src_ch = '0;
  logic        src_ext = 1'b0;
  logic [15:0] cfg_word = '0;
  logic        mode_pulse = 1'b0;
  logic        rearm = 1'b0;
  logic        trig_int, trig_out;

  int    total = 0;
  int    bad = 0;
  string cur_req = "R1";
  bit    finished = 1'b0;

  always #5 clk = ~clk;

  trig_combiner #(.PULSE_CYC(P)) uut (
    .clk(clk), .rst_n(rst_n), .src_ch(src_ch), .src_ext(src_ext),
    .cfg_word(cfg_word), .mode_pulse(mode_pulse), .rearm(rearm),
    .trig_int(trig_int), .trig_out(trig_out)
  );

  // reference model
  logic [4:0] hist[$];
  bit m_prev, m_trig, m_latch;
  int m_left;

  function automatic bit ref_fire(logic [4:0] s, logic [15:0] c);
    int need = 0, met = 0;
    bit any = 0;
    for (int i = 0; i < 5; i++) begin
      if (c[i] && s[i]) any = 1;
      if (c[8+i]) begin
        need++;
        if (s[i]) met++;
      end
    end
    return any || (need > 0 && met == need);
  endfunction

  function automatic bit exp_out();
    return mode_pulse ? (m_left > 0) : m_latch;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      hist = '{5'd0, 5'd0};
      m_prev = 0; m_trig = 0; m_latch = 0; m_left = 0;
    end else begin
      bit c, acc;
      c = ref_fire(hist[1], cfg_word);
      acc = c && !m_prev && !exp_out();
      m_trig = acc;
      if (acc) begin
        if (mode_pulse) m_left = P; else m_latch = 1;
      end else begin
        if (m_left > 0) m_left--;
        if (m_latch && rearm && !mode_pulse) m_latch = 0;
      end
      m_prev = c;
      hist.push_front({src_ext, src_ch});
      void'(hist.pop_back());
    end
  end

  task automatic check(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check(trig_int == m_trig, {cur_req, " trig_int"}, trig_int, m_trig);
      check(trig_out == exp_out(), {cur_req, " trig_out"}, trig_out, exp_out());
    end
  end

  task automatic wait_n(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic release_all();
    src_ch = '0; src_ext = 0;
    wait_n(4);
    rearm = 1; wait_n(1); rearm = 0;
    wait_n(P + 2);
  endtask

  int cnt;

  initial begin
    #2_000_000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    wait_n(3);
    check(trig_int == 0 && trig_out == 0, "R1 in reset", trig_out, 0);
    rst_n = 1;
    wait_n(1);
    check(trig_int == 0 && trig_out == 0, "R1 after reset", trig_out, 0);

    // R4 latency, R2 any-mask on src_ch[0]
    cur_req = "R4"; cfg_word = 16'h0001;
    wait_n(2);
    src_ch[0] = 1;
    @(posedge clk); @(posedge clk); #1;
    check(trig_int == 0, "R4 early", trig_int, 0);
    @(posedge clk); #1;
    check(trig_int == 1 && trig_out == 1, "R4 on time", trig_out, 1);
    release_all();

    // R2 each source through the any-mask
    cur_req = "R2";
    for (int i = 0; i < 5; i++) begin
      cfg_word = 16'h0001 << i;
      wait_n(2);
      if (i < 4) src_ch[i] = 1; else src_ext = 1;
      wait_n(5);
      check(trig_out == 1, "R2 any source", trig_out, 1);
      release_all();
    end

    // R3 all-mask: partial, full, empty
    cur_req = "R3"; cfg_word = 16'h1300;
    src_ch[0] = 1; src_ch[1] = 1; wait_n(6);
    check(trig_out == 0, "R3 partial", trig_out, 0);
    src_ext = 1; wait_n(5);
    check(trig_out == 1, "R3 full", trig_out, 1);
    release_all();
    cfg_word = 16'h0000; src_ch = 4'hF; src_ext = 1; wait_n(6);
    check(trig_out == 0, "R3 empty mask", trig_out, 0);
    release_all();

    // R10 unused bits and unmasked sources
    cur_req = "R10"; cfg_word = 16'hE0E0;
    src_ch = 4'hF; src_ext = 1; wait_n(6);
    check(trig_out == 0, "R10 reserved bits", trig_out, 0);
    release_all();
    cfg_word = 16'h0402; src_ch[0] = 1; src_ch[3] = 1; src_ext = 1; wait_n(6);
    check(trig_out == 0, "R10 unmasked", trig_out, 0);
    release_all();

    // R5 held level yields one trigger across restart
    cur_req = "R5"; cfg_word = 16'h0004;
    src_ch[2] = 1; wait_n(6);
    rearm = 1; wait_n(1); rearm = 0;
    wait_n(8);
    check(trig_out == 0, "R5 held level", trig_out, 0);
    release_all();

    // R6 R7 busy hold and ignore
    cur_req = "R7"; cfg_word = 16'h0011;
    src_ch[0] = 1; wait_n(5);
    src_ch[0] = 0; wait_n(2); src_ext = 1; wait_n(30);
    check(trig_out == 1, "R6 held busy", trig_out, 1);
    src_ext = 0; wait_n(3);
    cur_req = "R6";
    rearm = 1; wait_n(1); rearm = 0;
    check(trig_out == 0, "R6 released", trig_out, 0);
    src_ch[0] = 1; wait_n(5);
    check(trig_out == 1, "R7 new rise", trig_out, 1);
    release_all();

    // R9 rearm while idle
    cur_req = "R9";
    for (int i = 0; i < 4; i++) begin rearm = ~rearm; wait_n(1); end
    rearm = 0;
    check(trig_out == 0 && trig_int == 0, "R9 idle rearm", trig_out, 0);

    // R8 pulse mode width, rearm ignored, retrigger ignored
    cur_req = "R8"; mode_pulse = 1; cfg_word = 16'h0008;
    wait_n(2);
    src_ch[3] = 1; wait_n(3);
    cnt = 0;
    for (int i = 0; i < P + 10; i++) begin
      if (i == 3) rearm = 1;
      if (i == 4) begin rearm = 0; src_ch[3] = 0; end
      if (i == 6) src_ch[3] = 1;
      if (trig_out) cnt++;
      wait_n(1);
    end
    check(cnt == P, "R8 pulse width", cnt, P);
    src_ch[3] = 0; wait_n(4);
    src_ch[3] = 1; wait_n(4);
    check(trig_out == 1, "R8 next pulse", trig_out, 1);
    src_ch[3] = 0; wait_n(P + 4);
    mode_pulse = 0;
    wait_n(3);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule